// File: doc/BRIEF.md
# Remote Reconfiguration CSR Bridge

This block sits between a word-addressed memory-mapped slave port and a remote-reconfiguration engine. It does not store the configuration settings itself. Each bus read or write of a mapped setting becomes a single-cycle parameter access toward the engine. That access carries a 3-bit parameter code and a 2-bit read-source code, both taken from the address. The bridge then waits on the engine's busy handshake before it completes the bus transfer. Read data coming back from the engine is trimmed to the legal read width of the addressed setting. Write data going out is trimmed to the legal write width.

Two addresses at the top of the map are control addresses and have no storage behind them. A write to the first one fires a one-cycle watchdog-restart pulse toward the engine. A write to the second one raises a reconfigure request, which stays high until the engine signals completion. Read-only settings (boot mode and trigger cause) ignore writes. Reads of the control addresses, and of the unused words beside them, return zero without involving the engine.

The parameter `EXT_ADDR` selects the wide boot-address variant, which uses 32 bits in both directions. With `EXT_ADDR` at 0, the boot address is written as 24 bits and read back as 29 bits.

Top module: `rcfg_csr_bridge`

## Requirements
- R1: The word address is split so that address bits [1:0] appear on `eng_rsrc` and bits [4:2] appear on `eng_param` during the engine strobe. Parameter codes: 0 boot mode, 1 early-done option, 2 watchdog timeout, 3 watchdog enable, 4 boot address, 5 internal-oscillator option, 6 trigger cause, 7 control. Any nonzero address bit above bit 4 marks the word as unmapped.
- R2: Each engine access raises exactly one of `eng_rd` or `eng_wr`, for exactly one cycle.
- R3: `av_waitrequest` is high whenever `eng_busy` is high, and from the accepting edge of an engine access until the access completes.
- R4: A read of parameter codes 0 to 6 produces exactly one `av_readdatavalid` pulse, in the cycle after `eng_busy` is seen low following its assertion. The data is zero-extended from the read width: 2 bits for boot mode (00 factory, 01 application, 11 application with watchdog), 29 bits for the timeout, 5 bits for the trigger cause, 29 bits (32 with `EXT_ADDR`) for the boot address, and 1 bit for the other settings.
- R5: Write data sent on `eng_wdata` keeps only its legal write width. The timeout keeps 12 bits, the boot address keeps 24 bits (32 with `EXT_ADDR`), and the three 1-bit options keep bit 0.
- R6: Writes to word 0x00 and word 0x18 cause no engine strobe. Reads of words 0x1C to 0x1F, and of unmapped words, return zero through one `av_readdatavalid` pulse, with no engine strobe.
- R7: A write to word 0x1C with data bit 0 set raises `eng_reset_timer` for exactly one cycle. The same write with bit 0 clear has no effect.
- R8: A write to word 0x1D with data bit 0 set raises `eng_reconfig`, which stays high until a cycle in which `eng_done` is high and is low in the cycle after that. The same write with bit 0 clear has no effect.
- R9: After reset, `av_waitrequest`, `av_readdatavalid`, `eng_rd`, `eng_wr`, `eng_reset_timer` and `eng_reconfig` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| av_address | input | ADDR_W | Word address |
| av_read | input | 1 | Read request |
| av_write | input | 1 | Write request |
| av_writedata | input | 32 | Write data |
| av_readdata | output | 32 | Read data |
| av_readdatavalid | output | 1 | Read data valid strobe |
| av_waitrequest | output | 1 | Stall; a request is accepted when this is low |
| eng_param | output | 3 | Parameter code toward the engine |
| eng_rsrc | output | 2 | Read-source code toward the engine |
| eng_rd | output | 1 | Engine read strobe |
| eng_wr | output | 1 | Engine write strobe |
| eng_wdata | output | 32 | Masked write data toward the engine |
| eng_rdata | input | 32 | Parameter value from the engine |
| eng_busy | input | 1 | Engine busy |
| eng_done | input | 1 | Engine reports that reconfiguration has finished |
| eng_reset_timer | output | 1 | Watchdog restart pulse |
| eng_reconfig | output | 1 | Held reconfigure request |

## Verification
The assertions assume the engine behaves as follows. It raises `eng_busy` in the cycle after a strobe and keeps `eng_rdata` stable until busy falls. It pulses `eng_done` only while a reconfigure request is pending. The master never issues two accepted writes to word 0x1C on consecutive edges. The bench's engine model follows this timing, with a busy latency that rotates between one and four cycles. The driver waits for `av_waitrequest` to fall before each new request, so control writes are always separated by at least one idle cycle.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    localparam int DW = 32;

    typedef enum logic [2:0] {
        P_MODE   = 3'd0,
        P_EARLY  = 3'd1,
        P_WDTIME = 3'd2,
        P_WDEN   = 3'd3,
        P_BOOT   = 3'd4,
        P_OSC    = 3'd5,
        P_CAUSE  = 3'd6,
        P_CTRL   = 3'd7
    } param_e;

    typedef struct packed {
        logic            rd_eng;     // a read of this word goes to the engine
        logic            wr_eng;     // a write of this word goes to the engine
        logic            wr_timer;   // write fires watchdog restart pulse
        logic            wr_reconf;  // write raises reconfigure request
        param_e          param;
        logic [1:0]      rsrc;
        logic [DW-1:0]   wdata;      // already trimmed to write width
        logic [DW-1:0]   rmask;      // read width mask
    } acc_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } seq_e;

    function automatic logic [DW-1:0] width_mask(input int w);
        logic [DW:0] t;
        t = ((DW+1)'(1) << w) - (DW+1)'(1);
        return t[DW-1:0];
    endfunction

    function automatic int rd_width(input param_e p, input bit ext);
        case (p)
            P_MODE:   return 2;
            P_EARLY:  return 1;
            P_WDTIME: return 29;
            P_WDEN:   return 1;
            P_BOOT:   return ext ? 32 : 29;
            P_OSC:    return 1;
            P_CAUSE:  return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int wr_width(input param_e p, input bit ext);
        case (p)
            P_EARLY:  return 1;
            P_WDTIME: return 12;
            P_WDEN:   return 1;
            P_BOOT:   return ext ? 32 : 24;
            P_OSC:    return 1;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/rcfg_decode.sv
module rcfg_decode
    import rcfg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter bit EXT_ADDR = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output acc_t              acc
);
    localparam int PBITS = 3;
    localparam int SBITS = 2;

    logic   in_range;
    param_e p;

    generate
        if (ADDR_W > PBITS + SBITS) begin : g_hi
            assign in_range = ~|addr[ADDR_W-1:PBITS+SBITS];
        end else begin : g_nohi
            assign in_range = 1'b1;
        end
    endgenerate

    assign p = param_e'(addr[PBITS+SBITS-1:SBITS]);

    always_comb begin
        acc       = '0;
        acc.param = p;
        acc.rsrc  = addr[SBITS-1:0];
        acc.rmask = width_mask(rd_width(p, EXT_ADDR));
        acc.wdata = wdata & width_mask(wr_width(p, EXT_ADDR));
        if (in_range) begin
            acc.rd_eng    = (p != P_CTRL);
            acc.wr_eng    = (p == P_EARLY) || (p == P_WDTIME) || (p == P_WDEN) ||
                            (p == P_BOOT)  || (p == P_OSC);
            acc.wr_timer  = (p == P_CTRL) && (addr[SBITS-1:0] == 2'd0) && wdata[0];
            acc.wr_reconf = (p == P_CTRL) && (addr[SBITS-1:0] == 2'd1) && wdata[0];
        end
    end

endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq
    import rcfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          is_read,
    input  acc_t          acc_in,
    input  logic          eng_busy,
    input  logic [DW-1:0] eng_rdata,
    output logic          eng_rd,
    output logic          eng_wr,
    output logic [2:0]    eng_param,
    output logic [1:0]    eng_rsrc,
    output logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          stall
);
    seq_e   state_q;
    acc_t   acc_q;
    logic   dir_rd_q;
    logic   seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            acc_q    <= '0;
            dir_rd_q <= 1'b0;
            seen_q   <= 1'b0;
            rvalid   <= 1'b0;
            rdata    <= '0;
        end else begin
            rvalid <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        if (is_read) begin
                            if (acc_in.rd_eng) begin
                                acc_q    <= acc_in;
                                dir_rd_q <= 1'b1;
                                state_q  <= S_ISSUE;
                            end else begin
                                rvalid <= 1'b1;
                                rdata  <= '0;
                            end
                        end else if (acc_in.wr_eng) begin
                            acc_q    <= acc_in;
                            dir_rd_q <= 1'b0;
                            state_q  <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    seen_q  <= 1'b0;
                    state_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (eng_busy) begin
                        seen_q <= 1'b1;
                    end else if (seen_q) begin
                        state_q <= S_IDLE;
                        if (dir_rd_q) begin
                            rvalid <= 1'b1;
                            rdata  <= eng_rdata & acc_q.rmask;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign eng_rd    = (state_q == S_ISSUE) &&  dir_rd_q;
    assign eng_wr    = (state_q == S_ISSUE) && !dir_rd_q;
    assign eng_param = acc_q.param;
    assign eng_rsrc  = acc_q.rsrc;
    assign eng_wdata = acc_q.wdata;
    assign stall     = eng_busy || (state_q != S_IDLE);

endmodule

// File: rtl/rcfg_ctl.sv
module rcfg_ctl (
    input  logic clk,
    input  logic rst,
    input  logic kick_timer,
    input  logic kick_reconf,
    input  logic done,
    output logic timer_pulse,
    output logic reconf_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            timer_pulse <= 1'b0;
            reconf_hold <= 1'b0;
        end else begin
            timer_pulse <= kick_timer;
            if (done) begin
                reconf_hold <= 1'b0;
            end else if (kick_reconf) begin
                reconf_hold <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rcfg_csr_bridge.sv
module rcfg_csr_bridge
    import rcfg_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter bit EXT_ADDR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] av_address,
    input  logic              av_read,
    input  logic              av_write,
    input  logic [31:0]       av_writedata,
    output logic [31:0]       av_readdata,
    output logic              av_readdatavalid,
    output logic              av_waitrequest,
    output logic [2:0]        eng_param,
    output logic [1:0]        eng_rsrc,
    output logic              eng_rd,
    output logic              eng_wr,
    output logic [31:0]       eng_wdata,
    input  logic [31:0]       eng_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              eng_reset_timer,
    output logic              eng_reconfig
);
    acc_t acc;
    logic accept;
    logic wr_accept;

    rcfg_decode #(.ADDR_W(ADDR_W), .EXT_ADDR(EXT_ADDR)) u_dec (
        .addr  (av_address),
        .wdata (av_writedata),
        .acc   (acc)
    );

    assign accept    = (av_read || av_write) && !av_waitrequest;
    assign wr_accept = accept && !av_read;

    rcfg_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .is_read   (av_read),
        .acc_in    (acc),
        .eng_busy  (eng_busy),
        .eng_rdata (eng_rdata),
        .eng_rd    (eng_rd),
        .eng_wr    (eng_wr),
        .eng_param (eng_param),
        .eng_rsrc  (eng_rsrc),
        .eng_wdata (eng_wdata),
        .rdata     (av_readdata),
        .rvalid    (av_readdatavalid),
        .stall     (av_waitrequest)
    );

    rcfg_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .kick_timer  (wr_accept && acc.wr_timer),
        .kick_reconf (wr_accept && acc.wr_reconf),
        .done        (eng_done),
        .timer_pulse (eng_reset_timer),
        .reconf_hold (eng_reconfig)
    );

endmodule

// File: rtl/rcfg_csr_bridge_chk.sv
module rcfg_csr_bridge_chk #(
    parameter bit EXT_ADDR = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        av_waitrequest,
    input logic        av_readdatavalid,
    input logic        eng_rd,
    input logic        eng_wr,
    input logic [2:0]  eng_param,
    input logic [31:1] eng_wdata_hi,
    input logic        eng_busy,
    input logic        eng_done,
    input logic        eng_reset_timer,
    input logic        eng_reconfig
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(eng_rd && eng_wr)); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (eng_rd || eng_wr) |=> !(eng_rd || eng_wr)); // R2
    AST_STALL_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> av_waitrequest); // R3
    AST_STALL_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        (eng_rd || eng_wr) |-> av_waitrequest); // R3
    AST_RDV_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(av_readdatavalid) |-> !$past(eng_busy)); // R4
    AST_TIMEOUT_WMASK: assert property (@(posedge clk) disable iff (rst)
        (eng_wr && eng_param == 3'd2) |-> (eng_wdata_hi[31:12] == '0)); // R5
    AST_BIT_WMASK: assert property (@(posedge clk) disable iff (rst)
        (eng_wr && (eng_param == 3'd1 || eng_param == 3'd3 || eng_param == 3'd5))
        |-> (eng_wdata_hi == '0)); // R5
    AST_BOOT_WMASK: assert property (@(posedge clk) disable iff (rst)
        (eng_wr && eng_param == 3'd4 && !EXT_ADDR) |-> (eng_wdata_hi[31:24] == '0)); // R5
    AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        eng_wr |-> (eng_param != 3'd0 && eng_param != 3'd6 && eng_param != 3'd7)); // R6
    AST_CTRL_NO_READ: assert property (@(posedge clk) disable iff (rst)
        eng_rd |-> (eng_param != 3'd7)); // R6
    AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (rst)
        eng_reset_timer |=> !eng_reset_timer); // R7
    AST_RECONF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eng_reconfig && !eng_done) |=> eng_reconfig); // R8
    AST_RECONF_DROP: assert property (@(posedge clk) disable iff (rst)
        (eng_reconfig && eng_done) |=> !eng_reconfig); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !(eng_rd || eng_wr || av_readdatavalid || eng_reset_timer)); // R9
endmodule

bind rcfg_csr_bridge rcfg_csr_bridge_chk #(.EXT_ADDR(EXT_ADDR)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .av_waitrequest   (av_waitrequest),
    .av_readdatavalid (av_readdatavalid),
    .eng_rd           (eng_rd),
    .eng_wr           (eng_wr),
    .eng_param        (eng_param),
    .eng_wdata_hi     (eng_wdata[31:1]),
    .eng_busy         (eng_busy),
    .eng_done         (eng_done),
    .eng_reset_timer  (eng_reset_timer),
    .eng_reconfig     (eng_reconfig)
);

// File: tb/rcfg_csr_bridge_test.sv
module rcfg_csr_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  av_address = '0;
    logic        av_read = 1'b0;
    logic        av_write = 1'b0;
    logic [31:0] av_writedata = '0;
    logic [31:0] av_readdata;
    logic        av_readdatavalid;
    logic        av_waitrequest;
    logic [2:0]  eng_param;
    logic [1:0]  eng_rsrc;
    logic        eng_rd, eng_wr;
    logic [31:0] eng_wdata;
    logic [31:0] eng_rdata;
    logic        eng_busy;
    logic        eng_done = 1'b0;
    logic        eng_reset_timer, eng_reconfig;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcfg_csr_bridge uut (
        .clk(clk), .rst(rst), .av_address(av_address), .av_read(av_read),
        .av_write(av_write), .av_writedata(av_writedata), .av_readdata(av_readdata),
        .av_readdatavalid(av_readdatavalid), .av_waitrequest(av_waitrequest),
        .eng_param(eng_param), .eng_rsrc(eng_rsrc), .eng_rd(eng_rd), .eng_wr(eng_wr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .eng_busy(eng_busy),
        .eng_done(eng_done), .eng_reset_timer(eng_reset_timer), .eng_reconfig(eng_reconfig)
    );

    // Behavioural engine stand-in
    logic [31:0] regs [8];
    int          lat_sel = 1;
    int          busy_cnt;
    int          n_strobe = 0;
    logic [2:0]  last_p;
    logic [1:0]  last_r;

    always @(posedge clk) begin
        if (rst) begin
            eng_busy  <= 1'b0;
            busy_cnt  <= 0;
            eng_rdata <= '0;
            for (int i = 0; i < 8; i++) regs[i] <= '0;
            regs[0] <= 32'hFFFF_FFFD;
            regs[6] <= 32'hFFFF_FFEA;
        end else if (eng_rd || eng_wr) begin
            eng_busy  <= 1'b1;
            busy_cnt  <= lat_sel;
            last_p    <= eng_param;
            last_r    <= eng_rsrc;
            n_strobe  <= n_strobe + 1;
            eng_rdata <= regs[eng_param] | 32'hE000_0000;
            if (eng_wr) regs[eng_param] <= eng_wdata;
        end else if (eng_busy) begin
            if (busy_cnt <= 1) eng_busy <= 1'b0;
            else busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          stray_rdv = 0;
    int          pulses = 0;
    int          pulse_runs = 0;
    int          stall_miss = 0;
    int          strobe_runs = 0;
    logic        prev_pulse = 1'b0;
    logic        prev_strobe = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (av_readdatavalid) begin
                if (exp_q.size() == 0) begin
                    stray_rdv++;
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check("R4", t, av_readdata, e);
                end
            end
            if (eng_reset_timer) pulses++;
            if (eng_reset_timer && prev_pulse) pulse_runs++;
            prev_pulse = eng_reset_timer;
            if (eng_busy && !av_waitrequest) stall_miss++;
            if ((eng_rd || eng_wr) && prev_strobe) strobe_runs++;
            if (eng_rd && eng_wr) strobe_runs++;
            prev_strobe = eng_rd || eng_wr;
        end
    end

    task automatic bus_op(input logic [4:0] a, input logic rd, input logic [31:0] d);
        @(negedge clk);
        av_address   = a;
        av_read      = rd;
        av_write     = !rd;
        av_writedata = d;
        while (av_waitrequest) @(negedge clk);
        @(negedge clk);
        av_read  = 1'b0;
        av_write = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        while (av_waitrequest) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_op(a, 1'b1, '0);
        lat_sel = (lat_sel % 4) + 1;
        settle();
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        bus_op(a, 1'b0, d);
        lat_sel = (lat_sel % 4) + 1;
        settle();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL R3 watchdog: actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9", "waitrequest", 32'(av_waitrequest), 0);
        check("R9", "readdatavalid", 32'(av_readdatavalid), 0);
        check("R9", "strobes", 32'(eng_rd | eng_wr), 0);
        check("R9", "reset_timer/reconfig", 32'({eng_reset_timer, eng_reconfig}), 0);

        // R4 read-only values trimmed
        bus_rd(5'h00, 32'h1, "boot mode 2-bit");
        bus_rd(5'h18, 32'h0A, "trigger cause 5-bit");

        // R5 / R1 timeout write and read
        bus_wr(5'h08, 32'hFFFF_FFFF);
        check("R5", "timeout stored 12-bit", regs[2], 32'h0000_0FFF);
        check("R1", "param code timeout", 32'(last_p), 2);
        check("R1", "rsrc on word 0x08", 32'(last_r), 0);
        bus_rd(5'h08, 32'h0000_0FFF, "timeout 29-bit");

        // R5 boot address
        bus_wr(5'h10, 32'hDEAD_BEEF);
        check("R5", "boot addr stored 24-bit", regs[4], 32'h00AD_BEEF);
        bus_rd(5'h10, 32'h00AD_BEEF, "boot addr 29-bit");

        // R5 one-bit options
        bus_wr(5'h04, 32'hFFFF_FFFE);
        check("R5", "early-done stored", regs[1], 0);
        bus_wr(5'h0C, 32'h0000_0003);
        check("R5", "wd enable stored", regs[3], 1);
        bus_wr(5'h14, 32'h8000_0001);
        check("R5", "osc option stored", regs[5], 1);
        bus_rd(5'h0D, 32'h1, "wd enable via rsrc 1");
        check("R1", "rsrc on word 0x0D", 32'(last_r), 1);
        check("R1", "param code wd enable", 32'(last_p), 3);
        bus_rd(5'h16, 32'h1, "osc via rsrc 2");
        check("R1", "rsrc on word 0x16", 32'(last_r), 2);

        // R6 ignored writes and zero reads
        s0 = n_strobe;
        bus_wr(5'h00, 32'hFFFF_FFFF);
        bus_wr(5'h18, 32'hFFFF_FFFF);
        check("R6", "no strobe on read-only writes", n_strobe, s0);
        bus_rd(5'h00, 32'h1, "boot mode unchanged");
        bus_rd(5'h18, 32'h0A, "cause unchanged");
        s0 = n_strobe;
        bus_rd(5'h1C, 32'h0, "word 0x1C reads zero");
        bus_rd(5'h1F, 32'h0, "word 0x1F reads zero");
        check("R6", "no strobe on control reads", n_strobe, s0);

        // R7 watchdog restart pulse
        s0 = pulses;
        bus_wr(5'h1C, 32'h1);
        repeat (3) @(negedge clk);
        check("R7", "one pulse", pulses, s0 + 1);
        bus_wr(5'h1C, 32'hFFFF_FFFE);
        repeat (3) @(negedge clk);
        check("R7", "bit0 clear no pulse", pulses, s0 + 1);
        check("R7", "pulse width", pulse_runs, 0);

        // R8 reconfigure request
        bus_wr(5'h1D, 32'h0);
        check("R8", "bit0 clear no request", 32'(eng_reconfig), 0);
        bus_wr(5'h1D, 32'h1);
        repeat (4) @(negedge clk);
        check("R8", "request held", 32'(eng_reconfig), 1);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        check("R8", "request dropped after done", 32'(eng_reconfig), 0);
        repeat (2) @(negedge clk);
        check("R8", "request stays low", 32'(eng_reconfig), 0);

        repeat (4) @(negedge clk);
        check("R2", "single-cycle exclusive strobes", strobe_runs, 0);
        check("R3", "waitrequest low while busy", stall_miss, 0);
        check("R4", "unexpected readdatavalid", stray_rdv, 0);
        check("R4", "outstanding reads", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule